// File: doc/BRIEF.md
# Multichannel Chained DMA Controller

This block is a ten-channel DMA engine. It moves words between an internal memory port and a set of peripheral-side word ports, without help from the core. Each channel has four registers: an address index, a signed-free stride, a word count and a chain pointer. Software loads these through a register write port and then starts the channel. The channel then transfers one word each time its peripheral is ready and the memory port grants the access. The address steps by the stride and the count drops by one on each word.

When the count reaches zero, the channel raises a one-cycle completion interrupt. If chaining is enabled and the chain pointer is nonzero, the channel then reads a new descriptor from internal memory and carries on. A chain pointer of zero ends the chain. Two channels are paced by an off-chip device rather than by an on-chip peripheral. That device uses an asynchronous request input and a grant output. Every memory access waits on a grant input, so the core can hold the memory port whenever it needs it.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, mem_req, irq, per_ack and ext_gnt are all low.
- R2: A register write selects the channel with cfg_ch and the register with cfg_sel, and takes its value from cfg_wdata. The cfg_sel codes are: 0 index, 1 stride, 2 count, 3 chain pointer, 4 control. The control register bits are: bit0 start, bit1 chain enable, bit2 direction (0 = memory to peripheral, 1 = peripheral to memory). A write to a channel that is still active is ignored.
- R3: In the memory-to-peripheral direction, each word reads memory at the channel's index. That word appears on per_out while per_ack for the channel is high. The index then advances by the stride and the count drops by one.
- R4: In the peripheral-to-memory direction, each word writes the channel's per_in slice (bits ch*32 upward) to memory at the index. Addresses between the strided locations are not touched.
- R5: The completion interrupt is high for exactly one cycle. That cycle is the one right after the cycle of the channel's last word.
- R6: A channel started with a count of zero raises its interrupt in the cycle right after the start write, and it makes no memory access.
- R7: When chaining is enabled and the chain pointer P is nonzero, completion is followed by a descriptor load. The channel reads P, P+1, P+2 and P+3 into index, stride, count and chain pointer, in that order, and then resumes transferring. A zero pointer ends the chain after the interrupt.
- R8: When several channels need the memory port in the same cycle, the lowest-numbered channel is served first.
- R9: While mem_gnt is low, no word moves, and no channel's index or count advances.
- R10: Channels 8 and 9 are paced by ext_req[0] and ext_req[1] through a two-flop synchronizer, and their per_rdy bits are ignored. The first grant comes two cycles after ext_req rises. ext_gnt is high for one clock per word moved.
- R11: At most one channel transfers a word in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 4 | Channel selected for the write |
| cfg_sel | input | 3 | Register selected for the write |
| cfg_wdata | input | 32 | Write data |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Memory port granted to DMA this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data, valid in the granted cycle |
| per_rdy | input | 10 | Per-channel peripheral ready |
| per_in | input | 320 | Per-channel data from peripherals, 32 bits each |
| per_out | output | 32 | Word read from memory for the acknowledged channel |
| per_ack | output | 10 | Per-channel word-moved strobe |
| ext_req | input | 2 | Asynchronous requests for channels 8 and 9 |
| ext_gnt | output | 2 | Grants for channels 8 and 9 |
| irq | output | 10 | Per-channel completion interrupt |

## Verification
Two of the block's functions can fall in the same cycle. First, the descriptor load of one channel and the word transfers of others both compete for the single memory port. Second, two ordinary channels can become ready on the same edge. The bench provokes the second case by starting two channels while both peripherals are held not-ready, then raising both ready bits on the same edge. It judges the result by the full sequence of granted memory addresses, which must finish the lower channel before the higher one begins. In the chaining test, the address log must show the four descriptor reads, in order, between the last word of one transfer and the first word of the next.

// File: rtl/dma_chain_engine.sv
module dma_chain_engine #(
  parameter int NCH   = 10,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int CW    = 16,
  parameter int EXT_A = 8,
  parameter int EXT_B = 9,
  localparam int IW   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IW-1:0]     cfg_ch,
  input  logic [2:0]        cfg_sel,
  input  logic [DW-1:0]     cfg_wdata,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic [NCH-1:0]    per_rdy,
  input  logic [NCH*DW-1:0] per_in,
  output logic [DW-1:0]     per_out,
  output logic [NCH-1:0]    per_ack,
  input  logic [1:0]        ext_req,
  output logic [1:0]        ext_gnt,
  output logic [NCH-1:0]    irq
);

  logic [AW-1:0] idx_q [NCH];
  logic [AW-1:0] mod_q [NCH];
  logic [AW-1:0] cp_q  [NCH];
  logic [CW-1:0] cnt_q [NCH];
  logic [1:0]    step_q[NCH];
  logic [NCH-1:0] act_q, chn_q, dir_q, fet_q;
  logic [NCH-1:0] rdy, need, done;
  logic [1:0]     sy1_q, sy2_q;
  logic [IW-1:0]  sel;
  logic           win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sy1_q <= '0;
      sy2_q <= '0;
    end else begin
      sy1_q <= ext_req;
      sy2_q <= sy1_q;
    end
  end

  always_comb begin
    sel = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (need[i]) sel = IW'(i);
  end

  assign mem_req   = |need;
  assign win       = mem_req && mem_gnt;
  assign mem_addr  = fet_q[sel] ? cp_q[sel] + AW'(step_q[sel]) : idx_q[sel];
  assign mem_we    = mem_req && !fet_q[sel] && dir_q[sel];
  assign mem_wdata = per_in[sel*DW +: DW];
  assign per_out   = mem_rdata;
  assign irq       = done;
  assign ext_gnt   = {per_ack[EXT_B], per_ack[EXT_A]};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic mine;
    if (g == EXT_A)      begin : g_ea assign rdy[g] = sy2_q[0]; end
    else if (g == EXT_B) begin : g_eb assign rdy[g] = sy2_q[1]; end
    else                 begin : g_in assign rdy[g] = per_rdy[g]; end

    assign done[g]    = act_q[g] && !fet_q[g] && (cnt_q[g] == '0);
    assign need[g]    = act_q[g] && (fet_q[g] || ((cnt_q[g] != '0) && rdy[g]));
    assign mine       = win && (sel == IW'(g));
    assign per_ack[g] = mine && !fet_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        idx_q[g]  <= '0;
        mod_q[g]  <= '0;
        cp_q[g]   <= '0;
        cnt_q[g]  <= '0;
        step_q[g] <= '0;
        act_q[g]  <= 1'b0;
        chn_q[g]  <= 1'b0;
        dir_q[g]  <= 1'b0;
        fet_q[g]  <= 1'b0;
      end else if (done[g]) begin
        if (chn_q[g] && cp_q[g] != '0) begin
          fet_q[g]  <= 1'b1;
          step_q[g] <= '0;
        end else begin
          act_q[g] <= 1'b0;
        end
      end else if (mine) begin
        if (fet_q[g]) begin
          step_q[g] <= step_q[g] + 2'd1;
          case (step_q[g])
            2'd0: idx_q[g] <= mem_rdata[AW-1:0];
            2'd1: mod_q[g] <= mem_rdata[AW-1:0];
            2'd2: cnt_q[g] <= mem_rdata[CW-1:0];
            default: begin
              cp_q[g]  <= mem_rdata[AW-1:0];
              fet_q[g] <= 1'b0;
            end
          endcase
        end else begin
          idx_q[g] <= idx_q[g] + mod_q[g];
          cnt_q[g] <= cnt_q[g] - CW'(1);
        end
      end else if (cfg_we && cfg_ch == IW'(g) && !act_q[g]) begin
        case (cfg_sel)
          3'd0: idx_q[g] <= cfg_wdata[AW-1:0];
          3'd1: mod_q[g] <= cfg_wdata[AW-1:0];
          3'd2: cnt_q[g] <= cfg_wdata[CW-1:0];
          3'd3: cp_q[g]  <= cfg_wdata[AW-1:0];
          3'd4: begin
            act_q[g] <= cfg_wdata[0];
            chn_q[g] <= cfg_wdata[1];
            dir_q[g] <= cfg_wdata[2];
          end
          default: ;
        endcase
      end
    end

    AST_CNT_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] != $past(cnt_q[g]) && $past(act_q[g]) && !$past(fet_q[g])) |-> $past(per_ack[g])); // R3
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |=> !irq[g]); // R5
    AST_DONE_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> !per_ack[g]); // R6
  end

  AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_ack)); // R11
  AST_EXT_SYNC_A: assert property (@(posedge clk) disable iff (!rst_n)
    ext_gnt[0] |-> $past(ext_req[0], 2)); // R10
  AST_EXT_SYNC_B: assert property (@(posedge clk) disable iff (!rst_n)
    ext_gnt[1] |-> $past(ext_req[1], 2)); // R10

endmodule

// File: tb/test_dma_chain_engine.sv
module test_dma_chain_engine;
  localparam int NCH = 10;
  localparam int DW  = 32;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [3:0] cfg_ch = 0;
  logic [2:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic mem_req, mem_we, mem_gnt = 1;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata, per_out;
  logic [NCH-1:0] per_rdy = 0, per_ack, irq;
  logic [NCH*DW-1:0] per_in = 0;
  logic [1:0] ext_req = 0, ext_gnt;

  logic [31:0] mem [0:255];
  int nchk = 0, nerr = 0, cyc = 0;
  logic [31:0] got [NCH][16];
  int ngot[NCH], nirq[NCH], irq_cyc[NCH], last_ack[NCH];
  logic [15:0] alog [64];
  int nalog, nreq, nmulti, ngnt0, first_gnt, wr_cyc;

  always #10 clk = ~clk;

  dma_chain_engine i_dma_chain_engine (
    .clk, .rst_n, .cfg_we, .cfg_ch, .cfg_sel, .cfg_wdata,
    .mem_req, .mem_gnt, .mem_we, .mem_addr, .mem_wdata, .mem_rdata,
    .per_rdy, .per_in, .per_out, .per_ack, .ext_req, .ext_gnt, .irq);

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_gnt && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
  end

  always @(negedge clk) if (rst_n) begin
    for (int i = 0; i < NCH; i++) begin
      if (per_ack[i]) begin
        if (ngot[i] < 16) got[i][ngot[i]] = per_out;
        ngot[i]++;
        last_ack[i] = cyc;
      end
      if (irq[i]) begin nirq[i]++; irq_cyc[i] = cyc; end
    end
    if (mem_req && mem_gnt) begin
      if (nalog < 64) alog[nalog] = mem_addr;
      nalog++;
    end
    if (mem_req) nreq++;
    if ($countones(per_ack) > 1) nmulti++;
    if (ext_gnt[0]) begin
      if (ngnt0 == 0) first_gnt = cyc;
      ngnt0++;
    end
  end

  function automatic logic [31:0] iv(int a);
    return 32'(a * 3 + 1);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    for (int i = 0; i < NCH; i++) begin ngot[i] = 0; nirq[i] = 0; end
    nalog = 0; nreq = 0; ngnt0 = 0;
  endtask

  task automatic wr(input int ch, input int sel, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_ch = 4'(ch); cfg_sel = 3'(sel); cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    wr_cyc = cyc;
  endtask

  task automatic setup(input int ch, input int ix, input int md, input int ct, input int cp);
    wr(ch, 0, 32'(ix)); wr(ch, 1, 32'(md)); wr(ch, 2, 32'(ct)); wr(ch, 3, 32'(cp));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 100000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = iv(a);
    nmulti = 0;
    clear_logs();
    idle(3);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset", {22'd0, mem_req, irq, per_ack, ext_gnt}, 32'd0);

    // R3 memory to peripheral, stride 2; R5 irq timing
    clear_logs();
    setup(2, 16, 2, 4, 0);
    per_rdy = 10'b0000000100;
    wr(2, 4, 32'd1);
    idle(20);
    check("R3 count", 32'(ngot[2]), 32'd4);
    for (int k = 0; k < 4; k++) check("R3 data", got[2][k], iv(16 + 2 * k));
    check("R5 one irq", 32'(nirq[2]), 32'd1);
    check("R5 irq after last word", 32'(irq_cyc[2] - last_ack[2]), 32'd1);

    // R4 peripheral to memory, stride 3
    clear_logs();
    per_rdy = 0;
    per_in[3*DW +: DW] = 32'hA000_0003;
    setup(3, 100, 3, 5, 0);
    per_rdy = 10'b0000001000;
    wr(3, 4, 32'd5);
    idle(20);
    for (int k = 0; k < 5; k++) check("R4 written", mem[100 + 3 * k], 32'hA000_0003);
    check("R4 gap untouched", mem[101], iv(101));
    check("R4 beyond untouched", mem[115], iv(115));
    check("R5 irq ch3", 32'(nirq[3]), 32'd1);

    // R6 zero count at start
    clear_logs();
    per_rdy = 0;
    setup(1, 5, 1, 0, 0);
    per_rdy = 10'b0000000010;
    wr(1, 4, 32'd1);
    idle(1);
    check("R6 irq cycle", 32'(irq_cyc[1]), 32'(wr_cyc));
    idle(5);
    check("R6 irq count", 32'(nirq[1]), 32'd1);
    check("R6 no access", 32'(nreq), 32'd0);

    // R7 chaining
    clear_logs();
    per_rdy = 0;
    mem[200] = 32'd40; mem[201] = 32'd1; mem[202] = 32'd2; mem[203] = 32'd0;
    setup(4, 30, 1, 1, 200);
    per_rdy = 10'b0000010000;
    wr(4, 4, 32'd3);
    idle(25);
    check("R7 words", 32'(ngot[4]), 32'd3);
    check("R7 data0", got[4][0], iv(30));
    check("R7 data1", got[4][1], iv(40));
    check("R7 data2", got[4][2], iv(41));
    check("R7 irqs", 32'(nirq[4]), 32'd2);
    check("R7 accesses", 32'(nalog), 32'd7);
    check("R7 a0", 32'(alog[0]), 32'd30);
    for (int k = 0; k < 4; k++) check("R7 descriptor read", 32'(alog[1 + k]), 32'(200 + k));
    check("R7 a5", 32'(alog[5]), 32'd40);
    check("R7 a6", 32'(alog[6]), 32'd41);

    // R8 priority, R11 single transfer
    clear_logs();
    per_rdy = 0;
    setup(5, 50, 1, 3, 0);
    setup(6, 60, 1, 3, 0);
    wr(5, 4, 32'd1);
    wr(6, 4, 32'd1);
    per_rdy = 10'b0001100000;
    idle(20);
    check("R8 accesses", 32'(nalog), 32'd6);
    for (int k = 0; k < 3; k++) begin
      check("R8 low first", 32'(alog[k]), 32'(50 + k));
      check("R8 high after", 32'(alog[3 + k]), 32'(60 + k));
    end
    check("R11 multi ack", 32'(nmulti), 32'd0);

    // R9 stall
    clear_logs();
    per_rdy = 0;
    setup(7, 70, 1, 2, 0);
    per_rdy = 10'b0010000000;
    mem_gnt = 0;
    wr(7, 4, 32'd1);
    idle(10);
    check("R9 stalled", 32'(ngot[7]), 32'd0);
    mem_gnt = 1;
    idle(10);
    check("R9 resumed", 32'(ngot[7]), 32'd2);
    check("R9 data0", got[7][0], iv(70));
    check("R9 data1", got[7][1], iv(71));

    // R10 external pacing
    clear_logs();
    per_rdy = 0;
    setup(8, 80, 1, 3, 0);
    per_rdy = 10'b0100000000;
    wr(8, 4, 32'd1);
    idle(10);
    check("R10 per_rdy ignored", 32'(ngot[8]), 32'd0);
    @(posedge clk); #1;
    ext_req[0] = 1;
    wr_cyc = cyc;
    idle(15);
    check("R10 sync delay", 32'(first_gnt - wr_cyc), 32'd2);
    check("R10 grants", 32'(ngnt0), 32'd3);
    check("R10 words", 32'(ngot[8]), 32'd3);
    check("R10 data", got[8][2], iv(82));
    ext_req[0] = 0;

    // R2 write to active channel ignored
    clear_logs();
    per_rdy = 0;
    setup(9, 90, 1, 1, 0);
    wr(9, 4, 32'd1);
    wr(9, 0, 32'd10);
    ext_req[1] = 1;
    idle(10);
    check("R2 busy write ignored", got[9][0], iv(90));
    check("R2 ch9 words", 32'(ngot[9]), 32'd1);
    ext_req[1] = 0;

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule